// File: doc/BRIEF.md
# Integer ALU with Per-Operation Overflow Policy

This block is the combinational execute unit of a small 32-bit RISC core. It takes two operands, a five-bit shift count and a four-bit operation code, and returns a 32-bit result together with a single overflow-exception flag in the same cycle. There are no registers inside it. The caller samples the outputs whenever the inputs are stable.

Addition and subtraction come in two versions. The checked version raises the flag when the two's-complement result does not fit in the word. The unchecked version returns the same wrapped value and never raises the flag. The flag is only an indication. Holding back writeback and entering a trap handler are left to the surrounding pipeline. An add with an immediate operand uses the same operation codes as a register add. The decoder feeds the sign-extended immediate in on the second operand.

The block also provides three bitwise operations and three shifts: logical left, logical right and arithmetic right. The adder style is a parameter and can be either a behavioural sum or an explicit carry chain. The shifter is built from log2(width) generated barrel stages.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 (checked add, also used for add-immediate) returns the low 32 bits of operand A plus operand B.
- R2: With operation code 0, the flag is high exactly when A and B have the same sign bit and the sum's sign bit differs from it.
- R3: Operation code 2 (checked subtract) returns A minus B modulo 2^32. Its flag is high exactly when the sign bits of A and B differ and the result's sign bit differs from A's.
- R4: Operation codes 1 (unchecked add) and 3 (unchecked subtract) return the same wrapped value as codes 0 and 2, and their flag is always low.
- R5: Codes 4, 5 and 6 give the bit-by-bit AND, OR and NOR of A and B, each bit position computed on its own.
- R6: Code 7 shifts A left by the shift count. Bits leaving the top are discarded and the vacated low bits become zero.
- R7: Code 8 shifts A right by the shift count and fills the vacated high bits with zero.
- R8: Code 9 shifts A right by the shift count and fills the vacated high bits with A's bit 31, which rounds toward minus infinity (0xFFFFFFE7 shifted by 4 gives 0xFFFFFFFE).
- R9: A shift count of 0 makes codes 7, 8 and 9 return A unchanged. Counts range from 0 to 31.
- R10: The flag is low for every code other than 0 and 2. Codes 10 to 15 return a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; the value that is shifted |
| opnd_b | input | 32 | Second operand, from a register or a sign-extended immediate |
| shamt | input | 5 | Shift count |
| op_sel | input | 4 | Operation code, see R1 to R10 |
| result | output | 32 | Result of the selected operation |
| ovf_trap | output | 1 | Signed overflow flag for the checked add and subtract |

## Verification
The arithmetic codes are tried with the four sign combinations of the operands. These include both extremes, 0x7FFFFFFF and 0x80000000, so that overflow in each direction is separated from sums that merely carry out of bit 31. Each arithmetic vector is run under both its checked and its unchecked code, which shows that the two versions differ only in the flag. The shifts are tried with counts of 0, 1, 4 and 31 on values with the sign bit both set and clear. This separates zero fill from sign fill and exposes rounding errors such as -25 shifted by 4. A long run of pseudo-random operands over every code, including the unused codes, then compares each output against a reference model computed in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int ALU_OP_W = 4;

   typedef enum logic [ALU_OP_W-1:0] {
      OP_ADD_CHK = 4'd0,
      OP_ADD_WRP = 4'd1,
      OP_SUB_CHK = 4'd2,
      OP_SUB_WRP = 4'd3,
      OP_AND     = 4'd4,
      OP_OR      = 4'd5,
      OP_NOR     = 4'd6,
      OP_SHL     = 4'd7,
      OP_SHR_LOG = 4'd8,
      OP_SHR_ARI = 4'd9
   } alu_op_e;

   typedef enum logic [1:0] {
      LOGIC_AND = 2'd0,
      LOGIC_OR  = 2'd1,
      LOGIC_NOR = 2'd2,
      LOGIC_ZERO = 2'd3
   } logic_fn_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RLOG  = 2'd1,
      SH_RARI  = 2'd2
   } shift_fn_e;

   typedef enum logic [1:0] {
      SEL_ARITH = 2'd0,
      SEL_LOGIC = 2'd1,
      SEL_SHIFT = 2'd2,
      SEL_NONE  = 2'd3
   } res_sel_e;

   typedef struct packed {
      res_sel_e  sel;
      logic      sub;
      logic      chk;
      logic_fn_e lfn;
      shift_fn_e sfn;
   } alu_ctl_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W      = 32,
   parameter int ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              do_sub,
   output logic [DATA_W-1:0] sum,
   output logic              sgn_ovf
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("alu_addsub: DATA_W must be at least 2");
   end
   if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
      $error("alu_addsub: ADDER_STYLE must be 0 or 1");
   end

   logic [DATA_W-1:0] b_eff;
   assign b_eff = do_sub ? ~op_b : op_b;

   if (ADDER_STYLE == 0) begin : g_behav
      logic [DATA_W:0] wide;
      assign wide = {1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
      assign sum  = wide[MSB:0];
   end else begin : g_ripple
      logic [DATA_W:0] cy;
      assign cy[0] = do_sub;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum[i]  = op_a[i] ^ b_eff[i] ^ cy[i];
         assign cy[i+1] = (op_a[i] & b_eff[i]) | (cy[i] & (op_a[i] ^ b_eff[i]));
      end
   end

   // Overflow: effective operands share a sign and the result sign differs.
   assign sgn_ovf = (op_a[MSB] == b_eff[MSB]) && (sum[MSB] != op_a[MSB]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]       op_a,
   input  logic [DATA_W-1:0]       op_b,
   input  alu_pkg::logic_fn_e      fn,
   output logic [DATA_W-1:0]       res
);
   import alu_pkg::*;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      always_comb begin
         unique case (fn)
            LOGIC_AND: res[i] = op_a[i] & op_b[i];
            LOGIC_OR:  res[i] = op_a[i] | op_b[i];
            LOGIC_NOR: res[i] = ~(op_a[i] | op_b[i]);
            default:   res[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]  val,
   input  logic [SHAMT_W-1:0] amt,
   input  alu_pkg::shift_fn_e fn,
   output logic [DATA_W-1:0]  res
);
   import alu_pkg::*;
   localparam int MSB = DATA_W - 1;

   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_amt
      $error("alu_shift: DATA_W must equal 2**SHAMT_W");
   end

   logic              go_left;
   logic              fill;
   logic [DATA_W-1:0] pre;
   logic [DATA_W-1:0] stg [SHAMT_W+1];

   assign go_left = (fn == SH_LEFT);
   assign fill    = (fn == SH_RARI) ? val[MSB] : 1'b0;

   // Left shifts reuse the right barrel on a bit-reversed operand.
   for (genvar i = 0; i < DATA_W; i++) begin : g_pre
      assign pre[i] = go_left ? val[MSB-i] : val[i];
   end

   assign stg[0] = pre;
   for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
      localparam int DIST = 1 << s;
      assign stg[s+1] = amt[s] ? {{DIST{fill}}, stg[s][MSB:DIST]} : stg[s];
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_post
      assign res[i] = go_left ? stg[SHAMT_W][MSB-i] : stg[SHAMT_W][i];
   end
endmodule

// File: rtl/alu_decode.sv
module alu_decode (
   input  logic [alu_pkg::ALU_OP_W-1:0] op_sel,
   output alu_pkg::alu_ctl_t            ctl
);
   import alu_pkg::*;

   always_comb begin
      ctl = '{sel: SEL_NONE, sub: 1'b0, chk: 1'b0, lfn: LOGIC_ZERO, sfn: SH_LEFT};
      case (op_sel)
         OP_ADD_CHK: begin ctl.sel = SEL_ARITH; ctl.chk = 1'b1; end
         OP_ADD_WRP: begin ctl.sel = SEL_ARITH; end
         OP_SUB_CHK: begin ctl.sel = SEL_ARITH; ctl.sub = 1'b1; ctl.chk = 1'b1; end
         OP_SUB_WRP: begin ctl.sel = SEL_ARITH; ctl.sub = 1'b1; end
         OP_AND:     begin ctl.sel = SEL_LOGIC; ctl.lfn = LOGIC_AND; end
         OP_OR:      begin ctl.sel = SEL_LOGIC; ctl.lfn = LOGIC_OR; end
         OP_NOR:     begin ctl.sel = SEL_LOGIC; ctl.lfn = LOGIC_NOR; end
         OP_SHL:     begin ctl.sel = SEL_SHIFT; ctl.sfn = SH_LEFT; end
         OP_SHR_LOG: begin ctl.sel = SEL_SHIFT; ctl.sfn = SH_RLOG; end
         OP_SHR_ARI: begin ctl.sel = SEL_SHIFT; ctl.sfn = SH_RARI; end
         default:    ctl.sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
   parameter int DATA_W      = 32,
   parameter int SHAMT_W     = $clog2(DATA_W),
   parameter int ADDER_STYLE = 1
) (
   input  logic [DATA_W-1:0]            opnd_a,
   input  logic [DATA_W-1:0]            opnd_b,
   input  logic [SHAMT_W-1:0]           shamt,
   input  logic [alu_pkg::ALU_OP_W-1:0] op_sel,
   output logic [DATA_W-1:0]            result,
   output logic                         ovf_trap
);
   import alu_pkg::*;
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("alu_core: DATA_W must be at least 2");
   end

   alu_ctl_t          ctl;
   logic [DATA_W-1:0] as_res, lg_res, sh_res;
   logic              as_ovf;

   alu_decode i_dec (.op_sel(op_sel), .ctl(ctl));

   alu_addsub #(.DATA_W(DATA_W), .ADDER_STYLE(ADDER_STYLE)) i_addsub (
      .op_a(opnd_a), .op_b(opnd_b), .do_sub(ctl.sub), .sum(as_res), .sgn_ovf(as_ovf)
   );

   alu_logic #(.DATA_W(DATA_W)) i_logic (
      .op_a(opnd_a), .op_b(opnd_b), .fn(ctl.lfn), .res(lg_res)
   );

   alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) i_shift (
      .val(opnd_a), .amt(shamt), .fn(ctl.sfn), .res(sh_res)
   );

   always_comb begin
      unique case (ctl.sel)
         SEL_ARITH: result = as_res;
         SEL_LOGIC: result = lg_res;
         SEL_SHIFT: result = sh_res;
         default:   result = '0;
      endcase
      ovf_trap = (ctl.sel == SEL_ARITH) && ctl.chk && as_ovf;
   end

   always_comb begin
      if (!$isunknown({op_sel, opnd_a, opnd_b, shamt})) begin
         if (op_sel == OP_ADD_WRP || op_sel == OP_SUB_WRP)
            AST_NO_OVERFLOW: assert (!ovf_trap); // R4
         if (op_sel > OP_SUB_WRP)
            AST_FLAG_ARITH_ONLY: assert (!ovf_trap); // R10
         if (ovf_trap)
            AST_FLAG_SIGN_FLIP: assert (result[MSB] != opnd_a[MSB]); // R2
         if (op_sel == OP_ADD_CHK)
            AST_ADD_SUM: assert (result == opnd_a + opnd_b); // R1
         if (op_sel == OP_SUB_CHK)
            AST_SUB_DIFF: assert (result == opnd_a - opnd_b); // R3
         if (op_sel == OP_SHR_ARI)
            AST_SRA_SIGN: assert (result[MSB] == opnd_a[MSB]); // R8
         if (op_sel == OP_SHR_LOG && shamt != '0)
            AST_SRL_TOPZERO: assert (result[MSB] == 1'b0); // R7
         if (op_sel == OP_SHL && shamt != '0)
            AST_SLL_LOWZERO: assert (result[0] == 1'b0); // R6
         if ((op_sel == OP_SHL || op_sel == OP_SHR_LOG || op_sel == OP_SHR_ARI) && shamt == '0)
            AST_SHIFT_ZERO_PASS: assert (result == opnd_a); // R9
      end
   end
endmodule

// File: tb/test_alu_core.sv
module test_alu_core;
   localparam int W = 32;

   typedef struct {
      logic [3:0]   op;
      logic [W-1:0] a, b;
      logic [4:0]   sh;
      logic [W-1:0] exp_res;
      logic         exp_ovf;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] opnd_a = '0, opnd_b = '0;
   logic [4:0]   shamt = '0;
   logic [3:0]   op_sel = '0;
   logic [W-1:0] result;
   logic         ovf_trap;
   int           checks = 0, fails = 0;
   item_t        sbq[$];

   always #2.5 clk = ~clk;

   alu_core i_alu_core (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt), .op_sel(op_sel),
      .result(result), .ovf_trap(ovf_trap)
   );

   function automatic void ref_model(input logic [3:0] op, input logic [W-1:0] a, b,
                                     input logic [4:0] sh, output logic [W-1:0] r, output logic v);
      logic signed [W:0]   s;
      logic signed [W-1:0] sa;
      sa = a;
      v  = 1'b0;
      case (op)
         4'd0, 4'd1: begin
            s = $signed({a[W-1], a}) + $signed({b[W-1], b});
            r = s[W-1:0];
            v = (op == 4'd0) && (s[W] != s[W-1]);
         end
         4'd2, 4'd3: begin
            s = $signed({a[W-1], a}) - $signed({b[W-1], b});
            r = s[W-1:0];
            v = (op == 4'd2) && (s[W] != s[W-1]);
         end
         4'd4: r = a & b;
         4'd5: r = a | b;
         4'd6: r = ~(a | b);
         4'd7: r = a << sh;
         4'd8: r = a >> sh;
         4'd9: r = sa >>> sh;
         default: r = '0;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0: return "R1/R2";
         4'd2: return "R3";
         4'd1, 4'd3: return "R4";
         4'd4, 4'd5, 4'd6: return "R5";
         4'd7: return "R6";
         4'd8: return "R7";
         4'd9: return "R8";
         default: return "R10";
      endcase
   endfunction

   // Driver: applies one vector per cycle and queues the expected outcome.
   task automatic drive(input logic [3:0] op, input logic [W-1:0] a, b,
                        input logic [4:0] sh, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      opnd_a = a; opnd_b = b; shamt = sh; op_sel = op;
      it.op = op; it.a = a; it.b = b; it.sh = sh; it.tag = tag;
      ref_model(op, a, b, sh, it.exp_res, it.exp_ovf);
      sbq.push_back(it);
   endtask

   // Monitor: compares outputs mid-cycle against the head of the queue.
   always @(negedge clk) begin
      if (!rst && sbq.size() > 0) begin
         item_t it;
         it = sbq.pop_front();
         checks++;
         if (result !== it.exp_res || ovf_trap !== it.exp_ovf) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h ovf=%b, expected res=%h ovf=%b",
                     it.tag, it.op, it.a, it.b, it.sh, result, ovf_trap, it.exp_res, it.exp_ovf);
         end
      end
   end

   function automatic logic [W-1:0] xs(input logic [W-1:0] x);
      logic [W-1:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   task automatic run_all();
      logic [W-1:0] seed;
      // Reset state: zero inputs give zero result, no flag (R1)
      @(negedge clk);
      checks++;
      if (result !== '0 || ovf_trap !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset state: got res=%h ovf=%b, expected res=0 ovf=0", result, ovf_trap);
      end
      rst = 1'b0;
      // R1/R2 checked add and R4 unchecked twin
      for (int u = 0; u < 2; u++) begin
         logic [3:0] op;
         op = (u == 0) ? 4'd0 : 4'd1;
         drive(op, 32'd7, 32'd5, 5'd0, u == 0 ? "R1" : "R4");
         drive(op, 32'h7FFFFFFF, 32'd1, 5'd0, u == 0 ? "R2 pos ovf" : "R4");
         drive(op, 32'h80000000, 32'hFFFFFFFF, 5'd0, u == 0 ? "R2 neg ovf" : "R4");
         drive(op, 32'hFFFFFFFF, 32'd1, 5'd0, u == 0 ? "R2 carry no ovf" : "R4");
         drive(op, 32'd100, 32'hFFFFFFF6, 5'd0, u == 0 ? "R1 imm -10" : "R4");
      end
      // R3 checked subtract and R4 unchecked twin
      for (int u = 0; u < 2; u++) begin
         logic [3:0] op;
         op = (u == 0) ? 4'd2 : 4'd3;
         drive(op, 32'h80000000, 32'd1, 5'd0, u == 0 ? "R3 neg ovf" : "R4");
         drive(op, 32'd0, 32'h80000000, 5'd0, u == 0 ? "R3 pos ovf" : "R4");
         drive(op, 32'd5, 32'd9, 5'd0, u == 0 ? "R3 no ovf" : "R4");
         drive(op, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, u == 0 ? "R3 max-(-1)" : "R4");
      end
      // R5 bitwise
      drive(4'd4, 32'hF0F0A5A5, 32'hFF00FF00, 5'd0, "R5 and");
      drive(4'd5, 32'hF0F0A5A5, 32'h0F00FF00, 5'd0, "R5 or");
      drive(4'd6, 32'hF0F0A5A5, 32'h0F00FF00, 5'd0, "R5 nor");
      // R6..R9 shifts
      drive(4'd7, 32'h80000001, 32'd0, 5'd1, "R6 top bit lost");
      drive(4'd7, 32'h12345678, 32'd0, 5'd31, "R6 by 31");
      drive(4'd8, 32'h80000000, 32'd0, 5'd31, "R7 by 31");
      drive(4'd8, 32'hFFFFFFE7, 32'd0, 5'd4, "R7 zero fill");
      drive(4'd9, 32'hFFFFFFE7, 32'd0, 5'd4, "R8 -25>>4=-2");
      drive(4'd9, 32'h7FFFFFF0, 32'd0, 5'd4, "R8 positive");
      drive(4'd9, 32'h80000000, 32'd0, 5'd31, "R8 by 31");
      drive(4'd7, 32'hDEADBEEF, 32'd0, 5'd0, "R9 sll 0");
      drive(4'd8, 32'hDEADBEEF, 32'd0, 5'd0, "R9 srl 0");
      drive(4'd9, 32'hDEADBEEF, 32'd0, 5'd0, "R9 sra 0");
      // R10 unused codes and flag isolation
      drive(4'd12, 32'h7FFFFFFF, 32'd1, 5'd3, "R10 unused code");
      drive(4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd7, "R10 unused code");
      drive(4'd4, 32'h7FFFFFFF, 32'd1, 5'd0, "R10 no flag on and");
      // Pseudo-random sweep over all codes
      seed = 32'h1234ABCD;
      for (int k = 0; k < 400; k++) begin
         logic [W-1:0] a, b;
         seed = xs(seed); a = seed;
         seed = xs(seed); b = (k % 4 == 0) ? {seed[W-1], {(W-1){~seed[W-1]}}} : seed;
         drive(4'(k % 16), a, b, seed[4:0], tag_of(4'(k % 16)));
      end
      @(posedge clk);
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            fails++;
            $display("FAIL watchdog expired, queue=%0d expected 0", sbq.size());
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule